// File: doc/BRIEF.md
# Loop-Capable ROM Micro-Sequencer

This block is a compact controller built from a program counter and a read-only program store. The program counter advances through the store one word per clock. Each word carries an operation code, two address fields, a count field and a set of user control bits that drive an external datapath. The datapath itself is not part of the block.

Its main feature is counted loops in hardware. A loop word loads an end address, a begin address and an iteration count. Whenever the program counter reaches the end address while iterations remain, it reloads the begin address in the same cycle. Closing a loop therefore costs no decrement or branch words. The active loop's registers are saved on a hardware stack when a new loop starts, so loops can nest. They come back from the stack when the inner loop finishes or is left early with a break word. A conditional jump selects one of the condition inputs, or the constant "always". Two pulses tell user logic which end-of-body cycles loop back and which one is the final pass. Stack misuse is caught by two sticky error flags, and the sequencer freezes once either is set.

The program contents come in through a parameter, so each instance holds its own program, which is fixed when the design is elaborated.

Top module: `loop_seq`

## Requirements
- R1: While and right after synchronous reset `rst`, `pc_o` equals START_ADDR (default 0), both error flags are low and `ctrl_o` shows the user field of the word at START_ADDR.
- R2: Program word layout (36 bits): operation in bits [35:34] (0 step, 1 loop, 2 jump, 3 break), address field A in [33:27], address field B in [26:20], count in [19:12], user bits in [11:0]. A step word moves `pc_o` to the next address, wrapping from 127 to 0.
- R3: A loop word at address p loads count N, end address A and begin address B, then continues at p+1. When the end address is reached with more than one iteration left, the next address is B and the count drops by one, with no extra cycle. A body of k words runs N times in exactly N*k cycles.
- R4: A loop word with count 0 behaves as count 1: the body runs once.
- R5: Starting a loop pushes the enclosing loop's registers onto a 128-entry stack. When the inner loop finishes, execution falls through to end+1 with the enclosing loop restored, so nested loops run outer count times inner count passes.
- R6: `loop_back_o` is high in the end-address cycle of every non-final iteration, and `last_pass_o` in the end-address cycle of the final one. They are never high together, and they are high only at an end address whose word is a step or an untaken jump.
- R7: A jump word reads a selector from bits [22:20]: 0 means always, k in 1..4 means `cond_i[k-1]`, and 5..7 means never. When taken, `pc_o` becomes A, overriding any loop closing at that address. When not taken, the word acts as a step.
- R8: A break word leaves the current loop: the next address is the loop's end address plus one, the enclosing loop is restored from the stack, and `last_pass_o` stays low.
- R9: A loop word issued while 128 loops are already saved sets `ovf_err_o`, which stays high until reset. `pc_o` then holds its value and no loop pulse is produced.
- R10: A break word issued with an empty stack sets `unf_err_o`, which stays high until reset. `pc_o` then holds its value.
- R11: In every cycle `ctrl_o` equals the user field of the word addressed by `pc_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cond_i | input | 4 | Condition inputs for jump words |
| ctrl_o | output | 12 | User control bits of the current word |
| pc_o | output | 7 | Current program address |
| loop_back_o | output | 1 | End of a non-final loop iteration |
| last_pass_o | output | 1 | End of the final loop iteration |
| ovf_err_o | output | 1 | Sticky stack overflow flag |
| unf_err_o | output | 1 | Sticky stack underflow flag |

## Verification
One program combines loops with counts 0, 3, 5 and 2, and a two-deep nest of 2 by 4. It is run to its idle loop once with no jump condition active and once with the break condition active. The per-address visit counts and the arrival cycle are compared with products and sums of the loop counts. This separates a correct loop-back from off-by-one counting, a lost outer loop, a wrong fall-through after a break, and lost cycles at loop closure. A condition input that no jump selects is held high throughout to show that it has no effect. Separate runs drive the idle loop into repeated loop entries and into a break with nothing saved. These runs check the exact number of successful pushes before overflow, and that both error flags stay set and the program counter stays frozen.

// File: rtl/loop_seq_pkg.sv
package loop_seq_pkg;
   typedef enum logic [1:0] {
      OP_STEP  = 2'd0,
      OP_LOOP  = 2'd1,
      OP_JUMP  = 2'd2,
      OP_BREAK = 2'd3
   } seq_op_e;
endpackage

// File: rtl/loop_seq_rom.sv
module loop_seq_rom #(
   parameter int ADDR_W = 7,
   parameter int WORD_W = 36,
   parameter logic [(2**ADDR_W)*WORD_W-1:0] PROGRAM = '0
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [WORD_W-1:0] word_o
);
   localparam int DEPTH = 2**ADDR_W;

   logic [WORD_W-1:0] words [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      assign words[g] = PROGRAM[g*WORD_W +: WORD_W];
   end

   assign word_o = words[addr_i];
endmodule

// File: rtl/loop_seq_stack.sv
module loop_seq_stack #(
   parameter int ENT_W = 22,
   parameter int DEPTH = 128
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic [ENT_W-1:0] din_i,
   output logic [ENT_W-1:0] top_o,
   output logic             full_o,
   output logic             empty_o
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int PTR_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("loop_seq_stack: DEPTH must be at least 2");
   end

   logic [ENT_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0] sp;
   logic [PTR_W-1:0] sp_dec;

   assign sp_dec  = sp - 1'b1;
   assign full_o  = (sp == PTR_W'(DEPTH));
   assign empty_o = (sp == '0);
   assign top_o   = mem[sp_dec[IDX_W-1:0]];

   always_ff @(posedge clk) begin
      if (push_i) mem[sp[IDX_W-1:0]] <= din_i;
   end

   always_ff @(posedge clk) begin
      if (rst)                  sp <= '0;
      else if (push_i && !full_o) sp <= sp + 1'b1;
      else if (pop_i && !empty_o) sp <= sp_dec;
   end
endmodule

// File: rtl/loop_seq.sv
module loop_seq
   import loop_seq_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int WORD_W      = 36,
   parameter int CNT_W       = 8,
   parameter int STACK_DEPTH = 128,
   parameter int COND_N      = 4,
   parameter int START_ADDR  = 0,
   parameter logic [(2**ADDR_W)*WORD_W-1:0] PROGRAM = '0
) (
   input  logic                                 clk,
   input  logic                                 rst,
   input  logic [COND_N-1:0]                    cond_i,
   output logic [WORD_W-2-2*ADDR_W-CNT_W-1:0]   ctrl_o,
   output logic [ADDR_W-1:0]                    pc_o,
   output logic                                 loop_back_o,
   output logic                                 last_pass_o,
   output logic                                 ovf_err_o,
   output logic                                 unf_err_o
);
   localparam int USER_W = WORD_W - 2 - 2*ADDR_W - CNT_W;
   localparam int SEL_W  = $clog2(COND_N + 1);
   localparam int ENT_W  = 2*ADDR_W + CNT_W;
   localparam int A_LSB  = WORD_W - 2 - ADDR_W;
   localparam int B_LSB  = A_LSB - ADDR_W;
   localparam int C_LSB  = B_LSB - CNT_W;

   if (USER_W < 1) begin : g_bad_user
      $error("loop_seq: word too narrow for user bits");
   end
   if (SEL_W > ADDR_W) begin : g_bad_sel
      $error("loop_seq: condition selector does not fit field B");
   end
   if (START_ADDR >= 2**ADDR_W) begin : g_bad_start
      $error("loop_seq: START_ADDR outside program space");
   end

   logic [ADDR_W-1:0] pc_r, end_r, beg_r, pc_n, end_n, beg_n, pc_inc;
   logic [CNT_W-1:0]  cnt_r, cnt_n;
   logic              ovf_r, unf_r, err;
   logic [WORD_W-1:0] word;
   seq_op_e           op;
   logic [ADDR_W-1:0] fa, fb;
   logic [CNT_W-1:0]  fc;
   logic [SEL_W-1:0]  sel;
   logic [COND_N:0]   cond_ext;
   logic              cond_true, plain, at_end;
   logic              push, pop, ovf_hit, unf_hit, full, empty;
   logic [ENT_W-1:0]  saved;

   loop_seq_rom #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .PROGRAM(PROGRAM)) u_rom (
      .addr_i(pc_r), .word_o(word));

   assign op       = seq_op_e'(word[WORD_W-1 -: 2]);
   assign fa       = word[A_LSB +: ADDR_W];
   assign fb       = word[B_LSB +: ADDR_W];
   assign fc       = word[C_LSB +: CNT_W];
   assign ctrl_o   = word[USER_W-1:0];
   assign sel      = fb[SEL_W-1:0];
   assign cond_ext = {cond_i, 1'b1};

   always_comb begin
      cond_true = 1'b0;
      for (int k = 0; k <= COND_N; k++) begin
         if (sel == SEL_W'(k)) cond_true = cond_ext[k];
      end
   end

   assign err     = ovf_r | unf_r;
   assign pc_inc  = pc_r + 1'b1;
   assign at_end  = (pc_r == end_r) && (cnt_r != '0);
   assign plain   = (op == OP_STEP) || ((op == OP_JUMP) && !cond_true);
   assign loop_back_o = !err && plain && at_end && (cnt_r != CNT_W'(1));
   assign last_pass_o = !err && plain && at_end && (cnt_r == CNT_W'(1));
   assign ovf_hit = !err && (op == OP_LOOP) && full;
   assign unf_hit = !err && (op == OP_BREAK) && empty;
   assign push    = !err && (op == OP_LOOP) && !full;
   assign pop     = (!err && (op == OP_BREAK) && !empty) || last_pass_o;

   loop_seq_stack #(.ENT_W(ENT_W), .DEPTH(STACK_DEPTH)) u_stack (
      .clk(clk), .rst(rst), .push_i(push), .pop_i(pop),
      .din_i({cnt_r, end_r, beg_r}), .top_o(saved),
      .full_o(full), .empty_o(empty));

   always_comb begin
      pc_n  = pc_r;
      cnt_n = cnt_r;
      end_n = end_r;
      beg_n = beg_r;
      if (!err && !ovf_hit && !unf_hit) begin
         if (op == OP_LOOP) begin
            cnt_n = (fc == '0) ? CNT_W'(1) : fc;
            end_n = fa;
            beg_n = fb;
            pc_n  = pc_inc;
         end else if ((op == OP_JUMP) && cond_true) begin
            pc_n = fa;
         end else if (op == OP_BREAK) begin
            {cnt_n, end_n, beg_n} = saved;
            pc_n = end_r + 1'b1;
         end else if (loop_back_o) begin
            cnt_n = cnt_r - 1'b1;
            pc_n  = beg_r;
         end else if (last_pass_o) begin
            {cnt_n, end_n, beg_n} = saved;
            pc_n = pc_inc;
         end else begin
            pc_n = pc_inc;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_r  <= ADDR_W'(START_ADDR);
         cnt_r <= '0;
         end_r <= '0;
         beg_r <= '0;
         ovf_r <= 1'b0;
         unf_r <= 1'b0;
      end else begin
         pc_r  <= pc_n;
         cnt_r <= cnt_n;
         end_r <= end_n;
         beg_r <= beg_n;
         ovf_r <= ovf_r | ovf_hit;
         unf_r <= unf_r | unf_hit;
      end
   end

   assign pc_o      = pc_r;
   assign ovf_err_o = ovf_r;
   assign unf_err_o = unf_r;
endmodule

// File: rtl/loop_seq_chk.sv
module loop_seq_chk #(
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] pc,
   input logic [ADDR_W-1:0] beg,
   input logic              loop_back,
   input logic              last_pass,
   input logic              ovf,
   input logic              unf
);
   a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
      ovf |=> ovf);

   a_r10_unf_sticky: assert property (@(posedge clk) disable iff (rst)
      unf |=> unf);

   a_r9_pc_frozen: assert property (@(posedge clk) disable iff (rst)
      (ovf || unf) |=> (pc == $past(pc)));

   a_r9_no_pulse: assert property (@(posedge clk) disable iff (rst)
      (ovf || unf) |-> (!loop_back && !last_pass));

   a_r3_loop_target: assert property (@(posedge clk) disable iff (rst)
      loop_back |=> (pc == $past(beg)));

   a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
      loop_back |-> !last_pass);

   a_r5_fall_through: assert property (@(posedge clk) disable iff (rst)
      last_pass |=> (pc == ADDR_W'($past(pc) + 1'b1)));
endmodule

bind loop_seq loop_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst(rst), .pc(pc_r), .beg(beg_r),
   .loop_back(loop_back_o), .last_pass(last_pass_o),
   .ovf(ovf_err_o), .unf(unf_err_o));

// File: tb/test_loop_seq.sv
`timescale 1ns/1ps
module test_loop_seq;
   localparam int W  = 36;
   localparam int N  = 128;
   localparam int C1 = 0, C2 = 3, CO = 2, CI = 4, C5 = 5, C6 = 2;
   localparam int IDLE = 20;

   function automatic logic [W-1:0] mk(int op, int a, int b, int c, int tag);
      return {op[1:0], a[6:0], b[6:0], c[7:0], 12'(tag)};
   endfunction

   function automatic logic [N*W-1:0] build();
      logic [N*W-1:0] p;
      p = '0;
      for (int a = 0; a < N; a++) p[a*W +: W] = mk(0, 0, 0, 0, a);
      p[1*W  +: W] = mk(1, 3, 2, C1, 1);
      p[4*W  +: W] = mk(1, 6, 5, C2, 4);
      p[7*W  +: W] = mk(1, 12, 8, CO, 7);
      p[8*W  +: W] = mk(1, 10, 9, CI, 8);
      p[13*W +: W] = mk(1, 16, 14, C5, 13);
      p[14*W +: W] = mk(2, 30, 1, 0, 14);
      p[17*W +: W] = mk(1, 19, 18, C6, 17);
      p[20*W +: W] = mk(2, 40, 2, 0, 20);
      p[21*W +: W] = mk(2, 50, 3, 0, 21);
      p[22*W +: W] = mk(2, 20, 0, 0, 22);
      p[30*W +: W] = mk(3, 0, 0, 0, 30);
      p[40*W +: W] = mk(1, 41, 41, 1, 40);
      p[41*W +: W] = mk(2, 40, 0, 0, 41);
      p[50*W +: W] = mk(3, 0, 0, 0, 50);
      return p;
   endfunction

   localparam logic [N*W-1:0] PROG = build();

   logic        clk = 0, rst = 1;
   logic [3:0]  cond_i = '0;
   logic [11:0] ctrl_o;
   logic [6:0]  pc_o;
   logic        loop_back_o, last_pass_o, ovf_err_o, unf_err_o;

   loop_seq #(.PROGRAM(PROG)) i_loop_seq (
      .clk(clk), .rst(rst), .cond_i(cond_i), .ctrl_o(ctrl_o), .pc_o(pc_o),
      .loop_back_o(loop_back_o), .last_pass_o(last_pass_o),
      .ovf_err_o(ovf_err_o), .unf_err_o(unf_err_o));

   always #10 clk = ~clk;

   int checks = 0, errors = 0;
   int visits [N];
   int n_back, n_last, n_ctrl_bad, n_stray;
   bit done = 0;

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit is_end(int a);
      return a == 3 || a == 6 || a == 10 || a == 12 || a == 16 || a == 19;
   endfunction

   function automatic int exp_visit(int a, bit brk);
      case (a)
         0, 1, 4, 7, 13, 17: return 1;
         2, 3:               return (C1 == 0) ? 1 : C1;
         5, 6:               return C2;
         8, 11, 12:          return CO;
         9, 10:              return CO * CI;
         14:                 return brk ? 1 : C5;
         15, 16:             return brk ? 0 : C5;
         18, 19:             return C6;
         30:                 return brk ? 1 : 0;
         default:            return 0;
      endcase
   endfunction

   function automatic string req_of(int a);
      case (a)
         2, 3:            return "R4";
         8, 9, 10, 11, 12: return "R5";
         14, 15, 16, 30:  return "R8";
         0, 1, 4, 7, 13, 17: return "R2";
         default:         return "R3";
      endcase
   endfunction

   task automatic do_reset(logic [3:0] c);
      rst = 1;
      cond_i = c;
      repeat (3) @(negedge clk);
      rst = 0;
      chk("R1", "pc after reset", pc_o, 0);
      chk("R1", "ovf after reset", ovf_err_o, 0);
      chk("R1", "unf after reset", unf_err_o, 0);
      chk("R1", "ctrl after reset", ctrl_o, 0);
   endtask

   task automatic trace_to_idle(output int arrive);
      for (int a = 0; a < N; a++) visits[a] = 0;
      n_back = 0; n_last = 0; n_ctrl_bad = 0; n_stray = 0;
      arrive = -1;
      for (int c = 0; c < 2000; c++) begin
         if (pc_o == 7'(IDLE)) begin
            arrive = c;
            break;
         end
         visits[pc_o]++;
         if (loop_back_o) n_back++;
         if (last_pass_o) n_last++;
         if (loop_back_o && last_pass_o) n_stray++;
         if ((loop_back_o || last_pass_o) && !is_end(int'(pc_o))) n_stray++;
         if (ctrl_o != {5'b0, pc_o}) n_ctrl_bad++;
         @(negedge clk);
      end
   endtask

   task automatic run_program(bit brk);
      int arrive, exp_arrive, eb, el;
      exp_arrive = 0;
      for (int a = 0; a < 32; a++) exp_arrive += exp_visit(a, brk);
      trace_to_idle(arrive);
      chk("R3", "cycles to idle", arrive, exp_arrive);
      for (int a = 0; a < 32; a++) chk(req_of(a), $sformatf("visits at %0d", a),
                                       visits[a], exp_visit(a, brk));
      eb = (((C1 == 0) ? 1 : C1) - 1) + (C2 - 1) + (CO - 1) + CO * (CI - 1)
           + (brk ? 0 : C5 - 1) + (C6 - 1);
      el = 1 + 1 + 1 + CO + 1 + (brk ? 0 : 1);
      chk("R6", "loop_back pulses", n_back, eb);
      chk("R6", "last_pass pulses", n_last, el);
      chk("R6", "pulses off end address", n_stray, 0);
      chk("R11", "ctrl mismatches", n_ctrl_bad, 0);
   endtask

   initial begin
      int n41, guard;
      // R7: cond_i[3] is selected by no jump word and must change nothing
      do_reset(4'b1000);
      run_program(0);
      // R7: break condition cond_i[0] taken at address 14
      do_reset(4'b0001);
      run_program(1);

      // R9: idle loop diverted into repeated loop entry until the stack fills
      cond_i = 4'b0010;
      n41 = 0;
      guard = 0;
      while (!ovf_err_o && guard < 1000) begin
         @(negedge clk);
         if (pc_o == 7'd41) n41++;
         guard++;
      end
      chk("R9", "successful pushes before overflow", n41, 128);
      chk("R9", "pc at overflow", pc_o, 40);
      cond_i = 4'b0000;
      repeat (5) @(negedge clk);
      chk("R9", "ovf sticky", ovf_err_o, 1);
      chk("R9", "pc frozen", pc_o, 40);
      chk("R9", "no pulse while frozen", loop_back_o | last_pass_o, 0);
      chk("R10", "unf stays low on overflow", unf_err_o, 0);
      chk("R11", "ctrl while frozen", ctrl_o, 40);

      // R10: break with nothing saved
      do_reset(4'b0000);
      begin
         int arrive;
         trace_to_idle(arrive);
         chk("R7", "idle reached", arrive, 55);
      end
      cond_i = 4'b0100;
      repeat (4) @(negedge clk);
      cond_i = 4'b0000;
      repeat (4) @(negedge clk);
      chk("R10", "unf set", unf_err_o, 1);
      chk("R10", "pc frozen at break", pc_o, 50);
      chk("R9", "ovf low on underflow", ovf_err_o, 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual 1 expected 0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule